// File: doc/BRIEF.md
# Serial EEPROM Target Protocol Engine

This block is the bus-facing controller of an 8K x 8 serial memory that acts as a target on a two-wire I2C bus. It oversamples raw SCL and SDA with the system clock through a two-flop synchronizer. From the synchronized samples it detects START and STOP conditions, shifts in a device select byte and compares it with the three strap inputs. It takes a two-byte memory address and answers every byte it accepts with an ACK. SDA is driven only as an open-drain enable: a high `sda_oe_o` pulls the line low.

Reads come from an external array through a combinational read port (`rd_addr_o` / `rd_data_i`). The engine keeps one internal address counter that lives across transactions, so it supports current-address reads, selective reads and sequential reads that wrap over the whole array. Each accepted write data byte leaves as a one-cycle strobe with its address and data, for a separate page buffer. While the non-volatile write of that buffer is pending (`busy_i`), the engine refuses every byte.

States: `ST_IDLE`, `ST_SEL`, `ST_SEL_ACK`, `ST_AHI`, `ST_AHI_ACK`, `ST_ALO`, `ST_ALO_ACK`, `ST_WDAT`, `ST_WDAT_ACK`, `ST_RDAT`, `ST_RDAT_ACK`.

Transitions:
- STOP from any state goes to `ST_IDLE`, and START from any state goes to `ST_SEL`.
- At the SCL fall that ends each of `ST_SEL`, `ST_AHI`, `ST_ALO` and `ST_WDAT`, the engine moves to that state's `_ACK` state if the byte is accepted, or to `ST_IDLE` if it is refused.
- At the next SCL fall:
  - `ST_SEL_ACK` goes to `ST_RDAT` for a read select or to `ST_AHI` for a write select.
  - `ST_AHI_ACK` goes to `ST_ALO`.
  - `ST_ALO_ACK` and `ST_WDAT_ACK` go to `ST_WDAT`.
- After the eighth bit, `ST_RDAT` goes to `ST_RDAT_ACK`. That state returns to `ST_RDAT` if the controller acknowledged the byte, and otherwise goes to `ST_IDLE`.

Top module: `i2c_eeprom_target`

## Requirements
- R1: Until a START (SDA falling while SCL is high) is seen, clocked traffic gets no response and SDA stays released. A STOP (SDA rising while SCL is high) returns the engine to idle.
- R2: The select byte is accepted only when its upper four bits are 1010 and the next three bits equal `strap_i[2:0]`. Bit 0 is the direction: 1 for read, 0 for write. On a mismatch the engine answers NoACK and ignores the bus until the next START.
- R3: Every accepted select, address and write data byte is answered by SDA held low for the whole ninth SCL clock.
- R4: After a write select, the high address byte comes first and then the low byte. Only the low 13 bits are kept, and bits 15 to 13 are ignored.
- R5: Each accepted write data byte produces a one-cycle `wr_stb_o` carrying the current internal address and the byte. The internal address then advances by one, so consecutive bytes go to consecutive addresses.
- R6: A read select that has no address phase returns the byte at the internal address. After reset that address is 0. After any read or written byte, the address holds the last accessed address plus one.
- R7: A write select and two address bytes, followed by a repeated START and a read select, return the byte at the given address.
- R8: When the controller ACKs a read byte, the next byte is sent, and the address wraps from 8191 to 0. After a NoACK the engine releases SDA and stays idle.
- R9: While `busy_i` is high at the moment a byte is judged, that byte (select, address or data) gets NoACK, no strobe is produced, and the engine goes idle.
- R10: A START or STOP in the middle of a byte aborts that byte without a write strobe. A START proceeds to select matching.
- R11: The engine changes SDA only while SCL is low: input bits are taken on the rising SCL edge and output bits change after the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL level |
| sda_i | input | 1 | Raw SDA level as seen on the wire |
| strap_i | input | 3 | Device address straps compared with select bits 3..1 |
| busy_i | input | 1 | Internal write in progress; all bytes refused |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| rd_addr_o | output | 13 | Internal address presented to the array read port |
| rd_data_i | input | 8 | Array data for `rd_addr_o`, same cycle |
| wr_stb_o | output | 1 | One-cycle strobe for an accepted write byte |
| wr_addr_o | output | 13 | Address of the strobed write byte |
| wr_data_o | output | 8 | Strobed write byte |

## Verification
The engine judges a byte at the same SCL fall that `busy_i` may rise on. The ACK decision and the write-pending refusal can therefore land on the same clock. The bench raises `busy_i` while the select byte, an address byte or a data byte is being shifted. It then judges the result from the bus level sampled on the ninth clock and from the absence of a write strobe. A second coincidence is a START arriving while a data byte is half shifted. The bench checks it by confirming that no strobe leaves and that the following read returns the byte at the address set before the abort.

// File: rtl/eeprom_tgt_pkg.sv
package eeprom_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL,
        ST_SEL_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RDAT_ACK
    } state_e;

    // Fixed upper nibble of the select byte.
    localparam logic [3:0] SEL_PREFIX = 4'b1010;
    localparam int         STRAP_W    = 3;

endpackage

// File: rtl/eeprom_tgt_sync.sv
module eeprom_tgt_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    // One shift chain per bit; both bus lines idle high.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] sr;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sr <= '1;
            end else begin
                sr <= {sr[STAGES-2:0], d_i[b]};
            end
        end

        assign q_o[b] = sr[STAGES-1];
    end

endmodule

// File: rtl/eeprom_tgt_busmon.sv
module eeprom_tgt_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise_o = scl_i & ~scl_q;
    assign scl_fall_o = ~scl_i & scl_q;
    // SDA edges only count as conditions while SCL stays high on both samples.
    assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import eeprom_tgt_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap_i,
    input  logic              busy_i,
    output logic              sda_oe_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic              wr_stb_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o
);

    localparam int HI_W  = ADDR_W - 8;
    localparam int CNT_W = 4;
    localparam logic [CNT_W-1:0] BITS_PER_BYTE = CNT_W'(8);

    // ---------------- front end ----------------
    logic [1:0] synced;
    logic       scl_s;
    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_c;
    logic       stop_c;

    eeprom_tgt_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (synced)
    );

    assign scl_s = synced[1];
    assign sda_s = synced[0];

    eeprom_tgt_busmon u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_s),
        .sda_i      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_c),
        .stop_o     (stop_c)
    );

    // ---------------- state and datapath ----------------
    state_e            st_q;
    state_e            st_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [7:0]        sh_q;
    logic [HI_W-1:0]   ahi_q;
    logic [7:0]        tx_q;
    logic [ADDR_W-1:0] addr_q;
    logic              rw_q;
    logic              mack_q;
    logic              wr_stb_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [7:0]        wr_data_q;

    logic byte_end;
    logic sel_hit;
    logic counting;
    logic ahi_take;
    logic alo_take;
    logic wdat_take;
    logic enter_rd;

    assign byte_end = scl_fall && (cnt_q == BITS_PER_BYTE);
    assign sel_hit  = (sh_q[7:1] == {SEL_PREFIX, strap_i});
    assign counting = (st_q == ST_SEL) || (st_q == ST_AHI) || (st_q == ST_ALO)
                   || (st_q == ST_WDAT) || (st_q == ST_RDAT);

    // Next-state logic; bus conditions win over everything.
    always_comb begin
        st_d = st_q;
        if (stop_c) begin
            st_d = ST_IDLE;
        end else if (start_c) begin
            st_d = ST_SEL;
        end else begin
            unique case (st_q)
                ST_IDLE:     st_d = ST_IDLE;
                ST_SEL:      if (byte_end) st_d = (sel_hit && !busy_i) ? ST_SEL_ACK : ST_IDLE;
                ST_SEL_ACK:  if (scl_fall) st_d = rw_q ? ST_RDAT : ST_AHI;
                ST_AHI:      if (byte_end) st_d = busy_i ? ST_IDLE : ST_AHI_ACK;
                ST_AHI_ACK:  if (scl_fall) st_d = ST_ALO;
                ST_ALO:      if (byte_end) st_d = busy_i ? ST_IDLE : ST_ALO_ACK;
                ST_ALO_ACK:  if (scl_fall) st_d = ST_WDAT;
                ST_WDAT:     if (byte_end) st_d = busy_i ? ST_IDLE : ST_WDAT_ACK;
                ST_WDAT_ACK: if (scl_fall) st_d = ST_WDAT;
                ST_RDAT:     if (byte_end) st_d = ST_RDAT_ACK;
                ST_RDAT_ACK: if (scl_fall) st_d = mack_q ? ST_RDAT : ST_IDLE;
                default:     st_d = ST_IDLE;
            endcase
        end
    end

    assign ahi_take  = (st_q == ST_AHI)  && (st_d == ST_AHI_ACK);
    assign alo_take  = (st_q == ST_ALO)  && (st_d == ST_ALO_ACK);
    assign wdat_take = (st_q == ST_WDAT) && (st_d == ST_WDAT_ACK);
    assign enter_rd  = (st_d == ST_RDAT) && (st_q != ST_RDAT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            sh_q      <= '0;
            ahi_q     <= '0;
            tx_q      <= '1;
            addr_q    <= '0;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
            wr_stb_q  <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            wr_stb_q <= 1'b0;

            // bit counter and input shifter
            if (start_c || stop_c || byte_end) begin
                cnt_q <= '0;
            end else if (scl_rise && counting) begin
                sh_q  <= {sh_q[6:0], sda_s};
                cnt_q <= cnt_q + 1'b1;
            end

            if (scl_rise && (st_q == ST_RDAT_ACK)) begin
                mack_q <= ~sda_s;
            end

            if ((st_q == ST_SEL) && byte_end) begin
                rw_q <= sh_q[0];
            end

            if (ahi_take) begin
                ahi_q <= sh_q[HI_W-1:0];
            end

            // address counter: load, write step, read step
            if (alo_take) begin
                addr_q <= {ahi_q, sh_q};
            end else if (wdat_take) begin
                wr_stb_q  <= 1'b1;
                wr_addr_q <= addr_q;
                wr_data_q <= sh_q;
                addr_q    <= addr_q + 1'b1;
            end else if (enter_rd) begin
                addr_q <= addr_q + 1'b1;
            end

            // output shifter
            if (enter_rd) begin
                tx_q <= rd_data_i;
            end else if ((st_q == ST_RDAT) && scl_fall && !byte_end) begin
                tx_q <= {tx_q[6:0], 1'b1};
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        unique case (st_q)
            ST_SEL_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: sda_oe_o = 1'b1;
            ST_RDAT:                                         sda_oe_o = ~tx_q[7];
            default:                                         sda_oe_o = 1'b0;
        endcase
        rd_addr_o = addr_q;
        wr_stb_o  = wr_stb_q;
        wr_addr_o = wr_addr_q;
        wr_data_o = wr_data_q;
    end

endmodule

// File: rtl/eeprom_tgt_chk.sv
module eeprom_tgt_chk
    import eeprom_tgt_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              sda_oe,
    input logic              busy,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] rd_addr,
    input state_e            st
);

    // R11
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R9
    busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && (st != ST_RDAT)) |-> !$past(busy));

    // R5
    stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R5
    stb_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (rd_addr == ADDR_W'(wr_addr + 1'b1)));

endmodule

bind i2c_eeprom_target eeprom_tgt_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s   (scl_s),
    .sda_oe  (sda_oe_o),
    .busy    (busy_i),
    .wr_stb  (wr_stb_o),
    .wr_addr (wr_addr_o),
    .rd_addr (rd_addr_o),
    .st      (st_q)
);

// File: tb/sim_i2c_eeprom_target.sv
module sim_i2c_eeprom_target;

    localparam int ADDR_W = 13;
    localparam int Q      = 8;
    localparam logic [7:0] DEV_W = 8'hAA;   // 1010 + straps 101 + write
    localparam logic [7:0] DEV_R = 8'hAB;   // 1010 + straps 101 + read
    localparam int NVEC = 6;
    // {16-bit bus address, data byte}
    localparam logic [23:0] VEC [NVEC] = '{
        24'h0000_3C, 24'hE012_A5, 24'h1FFF_7E,
        24'hA800_00, 24'h6234_FF, 24'h0ABC_19
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              scl_drv = 1'b1;
    logic              sda_drv = 1'b1;
    logic              busy    = 1'b0;
    logic [2:0]        strap   = 3'b101;
    logic              sda_oe;
    logic              sda_line;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;
    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;

    function automatic logic [7:0] fdat(input logic [12:0] a);
        return a[7:0] ^ {a[12:8], 3'b101};
    endfunction

    assign sda_line = sda_drv & ~sda_oe;
    assign rd_data  = fdat(rd_addr);

    i2c_eeprom_target #(.ADDR_W(ADDR_W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_drv),
        .sda_i     (sda_line),
        .strap_i   (strap),
        .busy_i    (busy),
        .sda_oe_o  (sda_oe),
        .rd_addr_o (rd_addr),
        .rd_data_i (rd_data),
        .wr_stb_o  (wr_stb),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

    int checks = 0;
    int errors = 0;
    int stb_n = 0;
    logic [12:0] stb_a = '0;
    logic [7:0]  stb_d = '0;
    int hi_glitch = 0;
    logic scl_prev = 1'b1;
    logic oe_prev = 1'b0;

    always @(negedge clk) begin
        if (wr_stb) begin
            stb_n++;
            stb_a = wr_addr;
            stb_d = wr_data;
        end
        if (scl_drv && scl_prev && (sda_oe !== oe_prev)) hi_glitch++;
        scl_prev = scl_drv;
        oe_prev  = sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wq(Q);
        scl_drv = 1'b1; wq(Q);
        sda_drv = 1'b0; wq(Q);
        scl_drv = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wq(Q);
        scl_drv = 1'b1; wq(Q);
        sda_drv = 1'b1; wq(Q);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_drv = b;    wq(Q);
        scl_drv = 1'b1; wq(Q/2);
        s = sda_line;   wq(Q/2);
        scl_drv = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d[i] = s;
        end
        clk_bit(~mack, s);
    endtask

    task automatic set_addr(input logic [15:0] a, output logic ok);
        logic k0, k1, k2;
        bus_start();
        send_byte(DEV_W, k0);
        send_byte(a[15:8], k1);
        send_byte(a[7:0], k2);
        ok = k0 & k1 & k2;
    endtask

    task automatic rd_cur(output logic [7:0] d, output logic ok);
        bus_start();
        send_byte(DEV_R, ok);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic rd_sel(input logic [15:0] a, output logic [7:0] d, output logic ok);
        logic k0, k1;
        set_addr(a, k0);
        bus_start();
        send_byte(DEV_R, k1);
        recv_byte(1'b0, d);
        bus_stop();
        ok = k0 & k1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic ok, k, s;
        logic [7:0] d;
        int n0;

        wq(5);
        // reset state: R6 address 0, R1 bus released
        chk("R1 reset sda_oe", int'(sda_oe), 0);
        chk("R5 reset wr_stb", int'(wr_stb), 0);
        chk("R6 reset address", int'(rd_addr), 0);
        rst_n = 1'b1;
        wq(5);

        // R6: current read right after reset
        rd_cur(d, ok);
        chk("R3 ack read select", int'(ok), 1);
        chk("R6 current read at 0", int'(d), int'(fdat(13'h0)));

        // vector table: write, selective read, current read
        for (int i = 0; i < NVEC; i++) begin
            logic [15:0] va;
            logic [7:0]  vd;
            logic [12:0] a13;
            va  = VEC[i][23:8];
            vd  = VEC[i][7:0];
            a13 = va[12:0];
            n0  = stb_n;
            set_addr(va, ok);
            send_byte(vd, k);
            bus_stop();
            chk("R3 acks on byte write", int'(ok & k), 1);
            chk("R4 strobe address", int'(stb_a), int'(a13));
            chk("R5 strobe data", int'(stb_d), int'(vd));
            chk("R5 single strobe", stb_n - n0, 1);
            rd_sel(va, d, ok);
            chk("R7 selective read", int'(d), int'(fdat(a13)));
            rd_cur(d, ok);
            chk("R6 follow-up current read", int'(d), int'(fdat(a13 + 13'd1)));
        end

        // R5: page of three bytes
        n0 = stb_n;
        set_addr(16'h0040, ok);
        send_byte(8'h11, k);
        send_byte(8'h22, k);
        send_byte(8'h33, k);
        bus_stop();
        chk("R5 page strobe count", stb_n - n0, 3);
        chk("R5 page last address", int'(stb_a), 'h42);
        chk("R5 page last data", int'(stb_d), 'h33);
        rd_cur(d, ok);
        chk("R6 read after page write", int'(d), int'(fdat(13'h43)));

        // R2: strap mismatch and prefix mismatch
        bus_start();
        send_byte(8'hA2, k);
        chk("R2 strap mismatch nack", int'(k), 0);
        send_byte(DEV_W, k);
        chk("R2 ignored after mismatch", int'(k), 0);
        bus_stop();
        bus_start();
        send_byte(8'h3A, k);
        chk("R2 prefix mismatch nack", int'(k), 0);
        bus_stop();

        // R1: matching byte without START
        scl_drv = 1'b0; wq(Q);
        send_byte(DEV_W, k);
        chk("R1 no START no ack", int'(k), 0);
        bus_stop();

        // R9: busy on select, address and data bytes
        n0 = stb_n;
        busy = 1'b1;
        bus_start();
        send_byte(DEV_W, k);
        chk("R9 busy select nack", int'(k), 0);
        bus_stop();
        busy = 1'b0;
        bus_start();
        send_byte(DEV_W, k);
        busy = 1'b1;
        send_byte(8'h00, k);
        chk("R9 busy address nack", int'(k), 0);
        busy = 1'b0;
        bus_stop();
        set_addr(16'h0100, ok);
        busy = 1'b1;
        send_byte(8'h55, k);
        busy = 1'b0;
        bus_stop();
        chk("R9 busy data nack", int'(k), 0);
        chk("R9 no strobe while busy", stb_n - n0, 0);

        // R8: sequential read across the top of the array
        set_addr(16'h1FFE, ok);
        bus_start();
        send_byte(DEV_R, k);
        recv_byte(1'b1, d);
        chk("R8 seq byte 1FFE", int'(d), int'(fdat(13'h1FFE)));
        recv_byte(1'b1, d);
        chk("R8 seq byte 1FFF", int'(d), int'(fdat(13'h1FFF)));
        recv_byte(1'b1, d);
        chk("R8 seq wrap to 0", int'(d), int'(fdat(13'h0000)));
        recv_byte(1'b0, d);
        chk("R8 seq byte 1", int'(d), int'(fdat(13'h0001)));
        bus_stop();
        chk("R8 released after nack", int'(sda_oe), 0);
        rd_cur(d, ok);
        chk("R6 current read after sequence", int'(d), int'(fdat(13'h0002)));

        // R10: START in mid data byte
        n0 = stb_n;
        set_addr(16'h0123, ok);
        clk_bit(1'b1, s);
        clk_bit(1'b0, s);
        clk_bit(1'b1, s);
        clk_bit(1'b0, s);
        bus_start();
        send_byte(DEV_R, k);
        recv_byte(1'b0, d);
        bus_stop();
        chk("R10 start abort read ack", int'(k), 1);
        chk("R10 start abort data", int'(d), int'(fdat(13'h0123)));
        chk("R10 no strobe on abort", stb_n - n0, 0);

        // R10: STOP in mid select byte
        bus_start();
        clk_bit(1'b1, s);
        clk_bit(1'b0, s);
        clk_bit(1'b1, s);
        bus_stop();
        scl_drv = 1'b0; wq(Q);
        send_byte(DEV_R, k);
        chk("R10 stop abort then idle", int'(k), 0);
        bus_stop();

        // R11: SDA drive never changed during SCL high
        chk("R11 no change while SCL high", hi_glitch, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule